// File: doc/BRIEF.md
# Run-Length Sample Stream Decoder

This block turns compressed capture-memory contents back into a plain stream of logic samples. Capture data arrives as 32-bit words in groups of nine: eight words that each hold the low 32 bits of one record, followed by one word that packs the four upper bits of all eight records. The block joins each low word with its nibble to rebuild a 36-bit record. It then reads each record either as a sample, which carries a short built-in repeat, or as a repeat-count extension that lengthens the run of the sample before it.

Decoded samples leave through a valid/ready port, one 34-bit sample per cycle. A pulse on `start` begins a readout. It latches a total sample limit and clears all decoder state. A single-cycle `done` pulse closes the readout. It fires when the limit has been reached, which can cut a run short, or when the final slice, marked with `in_last`, has been fully decoded and no samples remain to be sent.

Top module: `rled_stream_decoder`

## Requirements
- R1: Each slice is nine input words. Words 0 to 7 give bits [31:0] of records 0 to 7. Word 8 gives bits [35:32] of all eight records: record i takes bits [31-4i:28-4i] of word 8, so record 0 uses the top nibble and record 7 uses the bottom nibble.
- R2: When the decoder expects a data record, bits [33:0] of that record become the value driven on `out_sample`.
- R3: Bit 34 of a data record sets the run of its sample: 1 when the bit is clear and 2 when it is set.
- R4: When bit 35 of a data record is set, the next record is a count record. The run grows by twice the full 36-bit value of the count record, and the record after it is again read as data.
- R5: `out_valid` and `out_ready` carry one sample per cycle. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` does not change.
- R6: After `start`, no more than `limit` samples are emitted, even if this ends a run early. The limit is taken from the `limit` port in the `start` cycle.
- R7: `start` clears the current sample, the pending run, the data/count expectation, the sample counter and any partly received slice.
- R8: `done` is a single-cycle pulse, given at most once per readout. It fires when the limit has been reached, or when the record of the slice whose ninth word came with `in_last` has been decoded and no run is pending. After it, `out_valid` stays low until the next `start`.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0, and no sample is emitted before the first `start`.
- R10: An input word is taken only in a cycle with `in_valid` and `in_ready` both high. `in_ready` stays low while a received slice is still being decoded, so a pending run holds back new input without losing any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a readout: clears state and latches `limit` |
| limit | input | LIMIT_W | Total number of samples to emit in this readout |
| in_valid | input | 1 | Input word present |
| in_word | input | 32 | Capture-memory word |
| in_last | input | 1 | Set together with the ninth word of the final slice |
| in_ready | output | 1 | Decoder can take an input word |
| out_valid | output | 1 | Sample present on `out_sample` |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | 34 | Decoded 34-channel sample |
| done | output | 1 | Single-cycle end-of-readout pulse |

## Verification
The bench builds the block with LIMIT_W set to 8. This keeps the limit register small enough that a sweep of every limit from zero to past the end of a test stream is short. It also makes the full-scale limit of 255 reachable by a run that a count record stretches to 302 samples. A sweep stream places every combination of the run-extension and count-follows flags, and every low nibble value, at varying lanes of the slice. That stream is sent under four back-pressure patterns. Further cases check that a count record uses its upper nibble, that a stream left waiting for a count record does not leak into the next readout, and that a readout cut off mid-slice is fully cleared by `start`.

// File: rtl/rled_pkg.sv
package rled_pkg;

    localparam int WORD_W      = 32;
    localparam int NIB_W       = 4;
    localparam int REC_W       = WORD_W + NIB_W;
    localparam int SMP_W       = REC_W - 2;
    localparam int LANES       = WORD_W / NIB_W;
    localparam int SLICE_WORDS = LANES + 1;
    localparam int LANE_W      = $clog2(LANES);
    localparam int IDX_W       = $clog2(SLICE_WORDS);
    localparam int RUN_W       = REC_W + 2;

    // 36-bit record viewed as a data record
    typedef struct packed {
        logic             more;   // next record is a count record
        logic             extra;  // sample repeats once more
        logic [SMP_W-1:0] smp;
    } data_rec_t;

    typedef enum logic {
        EXPECT_DATA  = 1'b0,
        EXPECT_COUNT = 1'b1
    } rec_mode_e;

    typedef enum logic {
        SB_FILL  = 1'b0,
        SB_DRAIN = 1'b1
    } sb_state_e;

    // Upper nibble of record 'lane': lane 0 sits at the top of the word
    function automatic logic [NIB_W-1:0] lane_nibble(
        input logic [WORD_W-1:0] hw,
        input logic [LANE_W-1:0] lane
    );
        logic [WORD_W-1:0] sh;
        sh = hw >> (WORD_W - NIB_W * (int'(lane) + 1));
        return sh[NIB_W-1:0];
    endfunction

endpackage

// File: rtl/rled_slice_buf.sv
module rled_slice_buf
    import rled_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    output logic              in_ready,
    output logic              rec_valid,
    output logic [REC_W-1:0]  rec_data,
    output logic              rec_last,
    input  logic              rec_ready
);

    sb_state_e         state_q;
    logic [IDX_W-1:0]  widx_q;
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] hi_q;
    logic              last_q;
    logic [WORD_W-1:0] low_q [LANES];

    logic take_word;
    assign in_ready  = (state_q == SB_FILL);
    assign take_word = in_ready && in_valid;

    // One holding register per lane for the low word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || start) begin
                low_q[g] <= '0;
            end else if (take_word && widx_q == IDX_W'(g)) begin
                low_q[g] <= in_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q <= SB_FILL;
            widx_q  <= '0;
            lane_q  <= '0;
            hi_q    <= '0;
            last_q  <= 1'b0;
        end else begin
            case (state_q)
                SB_FILL: begin
                    if (take_word) begin
                        if (widx_q == IDX_W'(LANES)) begin
                            hi_q    <= in_word;
                            last_q  <= in_last;
                            widx_q  <= '0;
                            lane_q  <= '0;
                            state_q <= SB_DRAIN;
                        end else begin
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                end
                SB_DRAIN: begin
                    if (rec_ready) begin
                        if (lane_q == LANE_W'(LANES - 1)) begin
                            state_q <= SB_FILL;
                        end else begin
                            lane_q <= lane_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SB_FILL;
            endcase
        end
    end

    assign rec_valid = (state_q == SB_DRAIN);
    assign rec_data  = {lane_nibble(hi_q, lane_q), low_q[lane_q]};
    assign rec_last  = last_q && (lane_q == LANE_W'(LANES - 1));

endmodule

// File: rtl/rled_run_core.sv
module rled_run_core
    import rled_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             halt,
    input  logic             rec_valid,
    input  logic [REC_W-1:0] rec_data,
    input  logic             rec_last,
    output logic             rec_ready,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_sample,
    input  logic             out_ready,
    output logic             beat,
    output logic             drained
);

    rec_mode_e        mode_q;
    logic [RUN_W-1:0] run_q;
    logic [SMP_W-1:0] smp_q;
    logic             end_q;

    data_rec_t        drec;
    logic             run_zero;
    logic             take;

    assign drec      = data_rec_t'(rec_data);
    assign run_zero  = (run_q == '0);
    assign rec_ready = run_zero && !halt && !end_q;
    assign take      = rec_valid && rec_ready;
    assign out_valid = !run_zero && !halt;
    assign beat      = out_valid && out_ready;
    assign drained   = end_q && run_zero;
    assign out_sample = smp_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            mode_q <= EXPECT_DATA;
            run_q  <= '0;
            smp_q  <= '0;
            end_q  <= 1'b0;
        end else if (take) begin
            end_q <= rec_last;
            if (mode_q == EXPECT_DATA) begin
                smp_q  <= drec.smp;
                run_q  <= RUN_W'(1) + RUN_W'(drec.extra);
                mode_q <= drec.more ? EXPECT_COUNT : EXPECT_DATA;
            end else begin
                run_q  <= run_q + RUN_W'({rec_data, 1'b0});
                mode_q <= EXPECT_DATA;
            end
        end else if (beat) begin
            run_q <= run_q - 1'b1;
        end
    end

endmodule

// File: rtl/rled_done_ctl.sv
module rled_done_ctl #(
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               beat,
    input  logic               drained,
    output logic               halt,
    output logic               done
);

    logic               armed_q;
    logic               sent_q;
    logic [LIMIT_W-1:0] lim_q;
    logic [LIMIT_W-1:0] emitted_q;
    logic               hit;
    logic               fire;

    assign hit  = (emitted_q >= lim_q);
    assign halt = !armed_q || hit;
    assign fire = armed_q && !sent_q && (hit || drained);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            sent_q    <= 1'b0;
            lim_q     <= '0;
            emitted_q <= '0;
            done      <= 1'b0;
        end else if (start) begin
            armed_q   <= 1'b1;
            sent_q    <= 1'b0;
            lim_q     <= limit;
            emitted_q <= '0;
            done      <= 1'b0;
        end else begin
            emitted_q <= emitted_q + LIMIT_W'(beat);
            done      <= fire;
            sent_q    <= sent_q || fire;
        end
    end

endmodule

// File: rtl/rled_stream_decoder.sv
module rled_stream_decoder
    import rled_pkg::*;
#(
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               in_valid,
    input  logic [31:0]        in_word,
    input  logic               in_last,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [33:0]        out_sample,
    output logic               done
);

    logic             rec_valid;
    logic [REC_W-1:0] rec_data;
    logic             rec_last;
    logic             rec_ready;
    logic             halt;
    logic             beat;
    logic             drained;

    rled_slice_buf u_slice (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .rec_valid (rec_valid),
        .rec_data  (rec_data),
        .rec_last  (rec_last),
        .rec_ready (rec_ready)
    );

    rled_run_core u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .halt       (halt),
        .rec_valid  (rec_valid),
        .rec_data   (rec_data),
        .rec_last   (rec_last),
        .rec_ready  (rec_ready),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_ready  (out_ready),
        .beat       (beat),
        .drained    (drained)
    );

    rled_done_ctl #(.LIMIT_W(LIMIT_W)) u_done (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .limit   (limit),
        .beat    (beat),
        .drained (drained),
        .halt    (halt),
        .done    (done)
    );

endmodule

// File: rtl/rled_stream_checker.sv
module rled_stream_checker #(
    parameter int LIMIT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [LIMIT_W-1:0] limit,
    input logic               out_valid,
    input logic               out_ready,
    input logic [33:0]        out_sample,
    input logic               done
);

    logic               armed_c;
    logic               seen_done;
    logic [LIMIT_W-1:0] cnt_c;
    logic [LIMIT_W-1:0] lim_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_c   <= 1'b0;
            seen_done <= 1'b0;
            cnt_c     <= '0;
            lim_c     <= '0;
        end else if (start) begin
            armed_c   <= 1'b1;
            seen_done <= 1'b0;
            cnt_c     <= '0;
            lim_c     <= limit;
        end else begin
            cnt_c <= cnt_c + LIMIT_W'(out_valid && out_ready);
            if (done) seen_done <= 1'b1;
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst || start)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

    assert_limit_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (armed_c && cnt_c < lim_c));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst || start)
        seen_done |-> !out_valid);

endmodule

bind rled_stream_decoder rled_stream_checker #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .limit      (limit),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .done       (done)
);

// File: tb/tb_rled_stream_decoder.sv
`timescale 1ns/1ps
module tb_rled_stream_decoder;

    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [LW-1:0] limit;
    logic          in_valid;
    logic [31:0]   in_word;
    logic          in_last;
    logic          in_ready;
    logic          out_valid;
    logic          out_ready;
    logic [33:0]   out_sample;
    logic          done;

    always #2.5 clk = ~clk;

    rled_stream_decoder #(.LIMIT_W(LW)) dut (
        .clk(clk), .rst(rst), .start(start), .limit(limit),
        .in_valid(in_valid), .in_word(in_word), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [35:0] recs [256];
    int          nrec;
    logic [33:0] expq [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add_data(input logic [33:0] s, input bit extra, input bit more);
        recs[nrec] = {more, extra, s};
        nrec++;
    endtask

    task automatic add_count(input logic [35:0] v);
        recs[nrec] = v;
        nrec++;
    endtask

    task automatic pad_recs();
        while (nrec % 8 != 0) add_data(34'h2_0000_0000 | 34'(nrec * 7), 1'b0, 1'b0);
    endtask

    // Expected sample stream, straight from the record rules
    task automatic build_exp(input int lim);
        bit mode = 0;
        logic [33:0] cur = '0;
        longint n;
        expq.delete();
        for (int i = 0; i < nrec; i++) begin
            if (!mode) begin
                cur  = recs[i][33:0];
                n    = 1 + longint'(recs[i][34]);
                mode = recs[i][35];
            end else begin
                n    = 2 * longint'(recs[i]);
                mode = 0;
            end
            for (longint k = 0; k < n && expq.size() < lim; k++) expq.push_back(cur);
        end
    endtask

    function automatic logic [31:0] word_at(input int w);
        int s = w / 9;
        int j = w % 9;
        logic [31:0] hw = '0;
        if (j < 8) return recs[s*8 + j][31:0];
        for (int l = 0; l < 8; l++) hw[31 - 4*l -: 4] = recs[s*8 + l][35:32];
        return hw;
    endfunction

    function automatic bit rpat_ready(input int rpat, input int cyc);
        case (rpat)
            0: return 1'b1;
            1: return (cyc % 2) == 0;
            2: return (cyc % 3) == 0;
            default: return (cyc % 5) != 4;
        endcase
    endfunction

    task automatic run_case(input string req, input int lim, input int rpat, input int abort_at);
        int nwords = (nrec / 8) * 9;
        int widx = 0, got = 0, mism = 0, donecnt = 0, holdbad = 0, tail = -1;
        bit stall = 0, rdy;
        logic [33:0] prev = '0, fa = '0, fe = '0;
        build_exp(lim);
        @(negedge clk);
        start = 1'b1; limit = LW'(lim); in_valid = 1'b0; out_ready = 1'b0; in_last = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (done) donecnt++;
            if (stall && !(out_valid && out_sample == prev)) holdbad++;
            if (abort_at >= 0 && got == abort_at) break;
            rdy = rpat_ready(rpat, cyc);
            out_ready = rdy;
            if (out_valid && rdy) begin
                if (got < expq.size() && out_sample != expq[got]) begin
                    if (mism == 0) begin fa = out_sample; fe = expq[got]; end
                    mism++;
                end
                got++;
            end
            stall = out_valid && !rdy;
            prev  = out_sample;
            if (widx < nwords) begin
                in_valid = 1'b1;
                in_word  = word_at(widx);
                in_last  = (widx == nwords - 1);
                if (in_ready) widx++;
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            if (donecnt > 0 && tail < 0) tail = 8;
            if (tail > 0) tail--;
            if (tail == 0) break;
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0; in_last = 1'b0;
        if (abort_at < 0) begin
            check(mism == 0, req, "sample value", longint'(fa), longint'(fe));
            check(got == expq.size(), {req, " R6"}, "sample count", got, expq.size());
            check(donecnt == 1, {req, " R8"}, "done pulses", donecnt, 1);
            if (rpat != 0) check(holdbad == 0, {req, " R5"}, "stall hold violations", holdbad, 0);
        end
    endtask

    // Every flag pair and low-nibble value, with count records 0..3
    task automatic build_sweep();
        nrec = 0;
        for (int f = 0; f < 4; f++)
            for (int b = 0; b < 4; b++) begin
                add_data({2'(b), 32'h9E37_79B9 * 32'(nrec + 1)}, f[0], f[1]);
                if (f[1]) add_count(36'((f * 4 + b) % 4));
            end
        pad_recs();
    endtask

    task automatic build_plain();
        nrec = 0;
        for (int i = 0; i < 16; i++)
            add_data({2'((i % 4) ^ (i / 4)), 32'hA5A5_0000 + 32'(i * 32'h1111)}, (i % 3) == 0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; limit = '0; in_valid = 1'b0; in_word = '0;
        in_last = 1'b0; out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(done == 1'b0, "R9", "done after reset", done, 0);

        // Nibble lanes, sample bits and short runs
        build_plain();
        run_case("R1 R2 R3", 255, 0, -1);

        // Flag and count sweep under back-pressure
        build_sweep();
        for (int rp = 0; rp < 4; rp++) run_case("R4 R5 R10", 255, rp, -1);

        // Every limit from zero past the end of the sweep stream
        begin
            int total;
            build_exp(100000);
            total = expq.size();
            for (int l = 0; l <= total + 1; l++) run_case("R6", l, 0, -1);
        end

        // Count record whose upper nibble matters, cut by the limit
        nrec = 0;
        add_data(34'h1_2345_6789, 1'b0, 1'b1);
        add_count(36'h1_0000_0003);
        pad_recs();
        run_case("R4 R6", 200, 2, -1);

        // Full-scale limit inside a long run
        nrec = 0;
        add_data(34'h3_0F0F_0F0F, 1'b1, 1'b1);
        add_count(36'd150);
        pad_recs();
        run_case("R6", 255, 0, -1);

        // Stream that leaves the decoder waiting for a count record
        nrec = 0;
        for (int i = 0; i < 7; i++) add_data(34'(i + 100), 1'b0, 1'b0);
        add_data(34'h0_DEAD_BEEF, 1'b0, 1'b1);
        run_case("R7 R8", 255, 0, -1);
        build_plain();
        run_case("R7", 255, 0, -1);

        // Readout aborted mid-slice, then a fresh one
        build_sweep();
        run_case("R7", 255, 1, 10);
        build_plain();
        run_case("R7", 255, 3, -1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule